// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the host-facing control register file of an audio codec. The host sees four byte-wide ports selected by a 2-bit address: an index port, a data port, a status port and a programmed-I/O data port. Through the index and data ports it reaches a bank of 32 indirect 8-bit control registers. Each indirect register is picked by the low bits of the index register. Whether 4 or 5 index bits are used depends on an extended-mode flag held inside the bank.

The block enforces the access rules of the bank:
- Some slots are reserved, and one slot is read-only.
- The sample-format register is guarded by mode-change enable bits.
- The mode register exposes only one writable bit.
- Interrupt state is cleared through the status port or through the feature-status register.
- Enabling mode change while calibration is configured makes the next read of the initialization-status register report busy.

A playback-completion pulse from the datapath raises the interrupt. Decoded control fields are brought out for the rest of the codec.

Top module: `cdc_index_regs`

## Requirements
- R1: After reset the index register holds 0x40, status bit 0 is 0 and the read data output is 0x00. Indirect slots 2, 3, 4, 5, 18 and 19 reset to 0x88. Slots 6 and 7 reset to 0x80, slot 9 to 0x08, slot 12 to 0x8A, and slots 25 and 26 to 0xA0. Every other slot resets to 0x00.
- R2: Port address 0 is the index register. Writes store bits 6..0, bit 7 always reads as 0, and bit 6 is the mode-change enable. A read strobe on any port places that port's value on the read data output at the clock edge that samples it, and the output then holds until the next read.
- R3: Port address 1 reads and writes the indirect slot chosen by the index register. When slot 12 bit 6 (extended mode) is 0, the index bits 3..0 choose the slot. When it is 1, index bits 4..0 choose the slot.
- R4: Writes to slots 11, 22, 27 and 29 leave them unchanged.
- R5: A write to slot 8 (format) is stored whole when index bit 6 is 1. If index bit 6 is 0 and slot 24 bit 4 is 1, only bits 7..4 are taken and bits 3..0 keep their old value. If both bits are 0, the write is dropped.
- R6: A write to slot 12 changes only its bit 6. A write to slot 9 always stores bit 5 as 0.
- R7: Any write to port address 2 clears the interrupt flag (status bit 0), clears slot 24 bits 6..4 and drives the interrupt output low.
- R8: A write to slot 24 that takes its bit 4 from 1 to 0 clears the interrupt flag and drives the interrupt output low.
- R9: A write to the index port that takes bit 6 from 0 to 1 while slot 9 bit 3 or bit 4 is 1 loads a calibration counter with CAL_READS. While the counter is non-zero, each data-port read of slot 11 returns bit 5 set and decrements the counter.
- R10: A playback-completion pulse sets the interrupt flag, sets slot 24 bit 4 and drives the interrupt output high. It takes precedence over a clear in the same cycle.
- R11: Port address 3 ignores writes and reads as 0x00. Port address 2 reads the interrupt flag in bit 0 and zeros in bits 7..1.
- R12: The decoded outputs follow the registers: play_en is slot 9 bit 0, irq_en is slot 10 bit 1, ext_mode is slot 12 bit 6, fmt_cfg is slot 8, and irq is the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_addr | input | 2 | Port select: 0 index, 1 data, 2 status, 3 programmed-I/O data |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| play_done | input | 1 | Playback-completion pulse from the datapath |
| irq | output | 1 | Interrupt output |
| play_en | output | 1 | Playback enable field |
| irq_en | output | 1 | Interrupt enable field |
| ext_mode | output | 1 | Extended-mode flag |
| fmt_cfg | output | 8 | Playback format register contents |

## Verification
Register and interrupt effects of a write or a completion pulse appear on the outputs one cycle after the strobe, at the edge that samples it. Read data likewise appears at the edge that samples the read strobe. This includes the decrement of the calibration counter, so a second read of slot 11 directly after the first already sees the updated count. The bench drives each strobe for one cycle and updates its behavioural model at that same rising edge. It then compares every output shortly after the edge, once per clock, so each result is checked in exactly the cycle it is due.

// File: rtl/cdc_regs_pkg.sv
package cdc_regs_pkg;

  localparam int BANK_DEPTH = 32;
  localparam int BYTE_W     = 8;
  localparam int SLOT_W     = $clog2(BANK_DEPTH);
  localparam int IDX_W      = 7;

  // slot numbers whose behaviour is special
  localparam int IX_FMT    = 8;
  localparam int IX_IFACE  = 9;
  localparam int IX_PINS   = 10;
  localparam int IX_INITST = 11;
  localparam int IX_MODE   = 12;
  localparam int IX_FEAT   = 24;

  localparam int MODE_EXT_BIT = 6;
  localparam int MCE_BIT      = 6;
  localparam int PMCE_BIT     = 4;
  localparam int BUSY_BIT     = 5;

  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_STATUS = 2'd2,
    PORT_PIO    = 2'd3
  } port_e;

  function automatic logic [BYTE_W-1:0] slot_reset(int unsigned n);
    case (n)
      2, 3, 4, 5, 18, 19: slot_reset = 8'h88;
      6, 7:               slot_reset = 8'h80;
      9:                  slot_reset = 8'h08;
      12:                 slot_reset = 8'h8A;
      25, 26:             slot_reset = 8'hA0;
      default:            slot_reset = 8'h00;
    endcase
  endfunction

  // effective slot number for the current index and mode
  function automatic logic [SLOT_W-1:0] slot_of(logic [IDX_W-1:0] idx, logic ext);
    slot_of = ext ? idx[SLOT_W-1:0] : {1'b0, idx[SLOT_W-2:0]};
  endfunction

  function automatic logic slot_locked(int unsigned n);
    slot_locked = (n == IX_INITST) || (n == 22) || (n == 27) || (n == 29);
  endfunction

  // value a slot takes after a data-port write
  function automatic logic [BYTE_W-1:0] slot_write(int unsigned n,
                                                   logic [BYTE_W-1:0] old,
                                                   logic [BYTE_W-1:0] wd,
                                                   logic mce, logic pmce);
    if (slot_locked(n)) begin
      slot_write = old;
    end else begin
      case (n)
        IX_FMT:   slot_write = mce  ? wd :
                               pmce ? {wd[7:4], old[3:0]} : old;
        IX_IFACE: slot_write = wd & 8'hDF;
        IX_MODE:  slot_write = {old[7], wd[MODE_EXT_BIT], old[5:0]};
        default:  slot_write = wd;
      endcase
    end
  endfunction

endpackage

// File: rtl/cdc_index_port.sv
module cdc_index_port
  import cdc_regs_pkg::*;
#(
  parameter int CAL_READS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_wdata,
  input  logic [1:0]       cal_cfg,
  input  logic             cal_take,
  output logic [IDX_W-1:0] idx_q,
  output logic             cal_busy,
  output logic             cal_arm
);

  localparam int CNT_W = (CAL_READS < 1) ? 1 : $clog2(CAL_READS + 1);

  logic [CNT_W-1:0] cal_cnt;

  assign cal_arm  = idx_we && !idx_q[MCE_BIT] && idx_wdata[MCE_BIT] && (|cal_cfg);
  assign cal_busy = (cal_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDX_W'(8'h40);
    end else if (idx_we) begin
      idx_q <= idx_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_cnt <= '0;
    end else if (cal_arm) begin
      cal_cnt <= CNT_W'(CAL_READS);
    end else if (cal_take && cal_busy) begin
      cal_cnt <= cal_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/cdc_ireg_bank.sv
module cdc_ireg_bank
  import cdc_regs_pkg::*;
#(
  parameter int DEPTH = BANK_DEPTH
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          slot_we,
  input  logic [SLOT_W-1:0]             slot_sel,
  input  logic [BYTE_W-1:0]             wdata,
  input  logic                          mce,
  input  logic                          stat_wr,
  input  logic                          done_evt,
  output logic [DEPTH-1:0][BYTE_W-1:0]  bank_q,
  output logic                          pend_drop
);

  logic pmce;

  assign pmce      = bank_q[IX_FEAT][PMCE_BIT];
  assign pend_drop = slot_we && (slot_sel == SLOT_W'(IX_FEAT))
                     && bank_q[IX_FEAT][PMCE_BIT] && !wdata[PMCE_BIT];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [SLOT_W-1:0] SELF = SLOT_W'(g);
    localparam logic [BYTE_W-1:0] INIT = slot_reset(g);

    logic [BYTE_W-1:0] q_r;
    logic [BYTE_W-1:0] nxt;

    always_comb begin
      nxt = q_r;
      if (slot_we && slot_sel == SELF) begin
        nxt = slot_write(g, q_r, wdata, mce, pmce);
      end
      if (g == IX_FEAT) begin
        if (stat_wr)  nxt[6:4]      = 3'b000;
        if (done_evt) nxt[PMCE_BIT] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= INIT;
      else        q_r <= nxt;
    end

    assign bank_q[g] = q_r;
  end

endmodule

// File: rtl/cdc_int_status.sv
module cdc_int_status (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_wr,
  input  logic pend_drop,
  input  logic done_evt,
  output logic int_q
);

  logic int_clear;

  assign int_clear = stat_wr || pend_drop;

  // completion wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         int_q <= 1'b0;
    else if (done_evt)  int_q <= 1'b1;
    else if (int_clear) int_q <= 1'b0;
  end

endmodule

// File: rtl/cdc_index_regs.sv
module cdc_index_regs
  import cdc_regs_pkg::*;
#(
  parameter int CAL_READS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic        play_done,
  output logic        irq,
  output logic        play_en,
  output logic        irq_en,
  output logic        ext_mode,
  output logic [7:0]  fmt_cfg
);

  port_e                              sel;
  logic                               wr_index, wr_data, wr_status;
  logic [IDX_W-1:0]                   idx_q;
  logic [SLOT_W-1:0]                  slot;
  logic [BANK_DEPTH-1:0][BYTE_W-1:0]  bank_q;
  logic                               pend_drop;
  logic                               cal_busy, cal_arm, cal_take;
  logic                               int_q;
  logic [BYTE_W-1:0]                  rd_next;

  assign sel       = port_e'(host_addr);
  assign wr_index  = host_wr && (sel == PORT_INDEX);
  assign wr_data   = host_wr && (sel == PORT_DATA);
  assign wr_status = host_wr && (sel == PORT_STATUS);

  assign ext_mode = bank_q[IX_MODE][MODE_EXT_BIT];
  assign slot     = slot_of(idx_q, ext_mode);
  assign cal_take = host_rd && (sel == PORT_DATA) && (slot == SLOT_W'(IX_INITST));

  cdc_index_port #(.CAL_READS(CAL_READS)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_we   (wr_index),
    .idx_wdata(host_wdata[IDX_W-1:0]),
    .cal_cfg  (bank_q[IX_IFACE][4:3]),
    .cal_take (cal_take),
    .idx_q    (idx_q),
    .cal_busy (cal_busy),
    .cal_arm  (cal_arm)
  );

  cdc_ireg_bank #(.DEPTH(BANK_DEPTH)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_we  (wr_data),
    .slot_sel (slot),
    .wdata    (host_wdata),
    .mce      (idx_q[MCE_BIT]),
    .stat_wr  (wr_status),
    .done_evt (play_done),
    .bank_q   (bank_q),
    .pend_drop(pend_drop)
  );

  cdc_int_status u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_wr  (wr_status),
    .pend_drop(pend_drop),
    .done_evt (play_done),
    .int_q    (int_q)
  );

  always_comb begin
    rd_next = '0;
    case (sel)
      PORT_INDEX:  rd_next = {1'b0, idx_q};
      PORT_DATA: begin
        rd_next = bank_q[slot];
        if (cal_busy && slot == SLOT_W'(IX_INITST)) rd_next[BUSY_BIT] = 1'b1;
      end
      PORT_STATUS: rd_next = {7'b0, int_q};
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_next;
  end

  assign irq     = int_q;
  assign play_en = bank_q[IX_IFACE][0];
  assign irq_en  = bank_q[IX_PINS][1];
  assign fmt_cfg = bank_q[IX_FMT];

endmodule

// File: rtl/cdc_index_regs_chk.sv
module cdc_index_regs_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [1:0]        host_addr,
  input logic [7:0]        host_wdata,
  input logic [7:0]        host_rdata,
  input logic              play_done,
  input logic              irq,
  input logic [6:0]        idx_q,
  input logic [4:0]        slot,
  input logic [31:0][7:0]  bank_q,
  input logic              pend_drop,
  input logic              cal_busy
);

  assert_index_msb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 2'd0 |=> host_rdata[7] == 1'b0);

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  assert_initst_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 2'd1 && slot == 5'd11 |=> $stable(bank_q[11]));

  assert_reserved_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 2'd1 && slot == 5'd22 |=> $stable(bank_q[22]));

  assert_fmt_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 2'd1 && slot == 5'd8 && !idx_q[6] && !bank_q[24][4]
    |=> $stable(bank_q[8]));

  assert_mode_low_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(bank_q[12][5:0]));

  assert_iface_bit5_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q[9][5] == 1'b0);

  assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 2'd2 && !play_done |=> !irq && bank_q[24][6:4] == 3'b000);

  assert_pend_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_drop && !play_done |=> !irq);

  assert_cal_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 2'd0 && !idx_q[6] && host_wdata[6] && (bank_q[9][4:3] != 2'b00)
    |=> cal_busy);

  assert_done_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    play_done |=> irq && bank_q[24][4]);

endmodule

bind cdc_index_regs cdc_index_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .host_rdata(host_rdata),
  .play_done (play_done),
  .irq       (irq),
  .idx_q     (idx_q),
  .slot      (slot),
  .bank_q    (bank_q),
  .pend_drop (pend_drop),
  .cal_busy  (cal_busy)
);

// File: tb/tb_cdc_index_regs.sv
module tb_cdc_index_regs;

  localparam int CLK_PERIOD = 10;
  localparam int CAL        = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       play_done = 1'b0;
  logic       irq, play_en, irq_en, ext_mode;
  logic [7:0] fmt_cfg;

  cdc_index_regs #(.CAL_READS(CAL)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .play_done(play_done), .irq(irq), .play_en(play_en), .irq_en(irq_en),
    .ext_mode(ext_mode), .fmt_cfg(fmt_cfg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;
  string cur_req  = "R1";

  // behavioural model
  int m_regs[32];
  int m_idx, m_int, m_cal, m_rdata;

  function automatic int default_of(int n);
    if (n inside {2, 3, 4, 5, 18, 19}) return 'h88;
    if (n == 6 || n == 7) return 'h80;
    if (n == 9) return 'h08;
    if (n == 12) return 'h8A;
    if (n == 25 || n == 26) return 'hA0;
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_regs[i] = default_of(i);
    m_idx = 'h40; m_int = 0; m_cal = 0; m_rdata = 0;
  endtask

  task automatic model_step(bit wr, bit rd, int a, int d, bit done);
    int ix, v;
    ix = ((m_regs[12] & 'h40) != 0) ? (m_idx % 32) : (m_idx % 16);
    if (rd) begin
      case (a)
        0: v = m_idx;
        1: begin
          v = m_regs[ix];
          if (ix == 11 && m_cal > 0) begin v = v | 'h20; m_cal--; end
        end
        2: v = m_int;
        default: v = 0;
      endcase
      m_rdata = v;
    end
    if (wr) begin
      case (a)
        0: begin
          if ((m_idx & 'h40) == 0 && (d & 'h40) != 0 && (m_regs[9] & 'h18) != 0) m_cal = CAL;
          m_idx = d & 'h7F;
        end
        1: begin
          if (ix == 8) begin
            if ((m_idx & 'h40) != 0) m_regs[8] = d;
            else if ((m_regs[24] & 'h10) != 0) m_regs[8] = (d & 'hF0) | (m_regs[8] & 'h0F);
          end else if (ix == 9) m_regs[9] = d & ~'h20 & 'hFF;
          else if (ix == 12) m_regs[12] = (m_regs[12] & ~'h40) | (d & 'h40);
          else if (ix == 24) begin
            if ((m_regs[24] & 'h10) != 0 && (d & 'h10) == 0) m_int = 0;
            m_regs[24] = d;
          end else if (!(ix inside {11, 22, 27, 29})) m_regs[ix] = d;
        end
        2: begin m_int = 0; m_regs[24] = m_regs[24] & 'h8F; end
        default: ;
      endcase
    end
    if (done) begin m_int = 1; m_regs[24] = m_regs[24] | 'h10; end
  endtask

  task automatic check(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("rdata",    host_rdata, m_rdata);
    check("irq",      irq,        m_int);
    check("play_en",  play_en,    m_regs[9] & 1);
    check("irq_en",   irq_en,     (m_regs[10] >> 1) & 1);
    check("ext_mode", ext_mode,   (m_regs[12] >> 6) & 1);
    check("fmt_cfg",  fmt_cfg,    m_regs[8]);
  endtask

  task automatic cyc(bit wr, bit rd, int a, int d, bit done);
    host_wr = wr; host_rd = rd; host_addr = a[1:0]; host_wdata = d[7:0]; play_done = done;
    @(posedge clk);
    model_step(wr, rd, a, d, done);
    #1;
    host_wr = 0; host_rd = 0; play_done = 0;
    #1;
    compare_all();
  endtask

  task automatic wr(int a, int d); cyc(1, 0, a, d, 0); endtask
  task automatic rd(int a);        cyc(0, 1, a, 0, 0); endtask
  task automatic wslot(int ix, int d); wr(0, 'h40 | ix); wr(1, d); endtask
  task automatic rslot(int ix);    wr(0, 'h40 | ix); rd(1); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    #(CLK_PERIOD * 2 + 2);
    cur_req = "R1"; compare_all();
    rst_n = 1'b1;
    #(CLK_PERIOD);

    // R2: index storage, bit 7 masked
    cur_req = "R2"; rd(0); check("index reset literal", host_rdata, 'h40);
    wr(0, 'hFF); rd(0); check("index msb", host_rdata, 'h7F);
    cyc(0, 0, 0, 0, 0); check("rdata hold", host_rdata, 'h7F);

    // R1 / R3: defaults in 4-bit mode, then in 5-bit mode
    cur_req = "R1";
    for (int i = 0; i < 16; i++) rslot(i);
    cur_req = "R6"; wslot(12, 'hFF); rslot(12); check("mode literal", host_rdata, 'hCA);
    cur_req = "R3";
    for (int i = 16; i < 32; i++) rslot(i);
    wslot(12, 'h00);
    wr(0, 'h5C); rd(1); check("alias 4-bit", host_rdata, 'h8A);
    wr(0, 'h52); rd(1); check("alias slot2", host_rdata, 'h88);
    wslot(12, 'h40);
    wr(0, 'h52); rd(1); check("5-bit slot18", host_rdata, 'h88);

    // R4: locked slots
    cur_req = "R4";
    wslot(22, 'h5A); rslot(22);
    wslot(27, 'hA5); rslot(27);
    wslot(29, 'h3C); rslot(29);
    wslot(11, 'hFF); rslot(11); check("initst literal", host_rdata, 'h00);
    wslot(20, 'h77); rslot(20);

    // R5: format gating
    cur_req = "R5";
    wslot(8, 'h5B); rslot(8);
    wr(0, 'h08); wr(1, 'hFF); rd(1);
    wslot(24, 'h10);
    wr(0, 'h08); wr(1, 'hA3); rd(1); check("format partial", host_rdata, 'hAB);

    // R6 / R12: interface config and decoded fields
    cur_req = "R6"; wslot(9, 'hFF); rslot(9); check("iface bit5", host_rdata, 'hDF);
    cur_req = "R12"; wslot(10, 'h02); wslot(9, 'h01); wslot(9, 'h18);

    // R10 / R11 / R7: interrupt raise and status clear
    cur_req = "R10"; cyc(0, 0, 0, 0, 1); rslot(24);
    cur_req = "R11"; rd(2); check("status bit0", host_rdata, 1);
    cur_req = "R7"; wslot(24, 'h70); wr(2, 'h00); rslot(24); rd(2);

    // R8: feature-status bit 4 falling
    cur_req = "R8"; cyc(0, 0, 0, 0, 1); wslot(24, 'h00); rd(2);
    cur_req = "R10"; cyc(1, 0, 2, 0, 1); rd(2);
    cur_req = "R7";  wr(2, 'h00);

    // R9: calibration busy (slot 9 = 0x18)
    cur_req = "R9";
    wr(0, 'h0B); wr(0, 'h4B); rd(1); check("busy read", host_rdata, 'h20);
    rd(1); check("busy spent", host_rdata, 'h00);
    wslot(9, 'h00); wr(0, 'h0B); wr(0, 'h4B); rd(1);

    // R11: PIO port
    cur_req = "R11"; wr(3, 'hFF); rd(3); rslot(20);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule